// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the program counter of a single-cycle 32-bit core that uses a five-kind control-flow encoding. On each enabled clock edge it loads the PC with the address of the next instruction to fetch. It derives that address from the instruction word currently presented and from the two source values the register file has read for it. Four kinds of target exist: the sequential address (PC plus four), a PC-relative target for the two compare-and-branch forms, a region-absolute target for the two direct jump forms, and a register-indirect target. For the call form the block also raises a one-cycle write-back request that carries the return address to the link register.

The surrounding core fetches `instr` from `pc`, reads the register file at the two source fields, and feeds both values back in the same cycle. The chosen address is visible combinationally on `next_pc` before the edge that loads it. The link request is meant to drive a register-file write port directly. Holding `en` low freezes the PC, so the core can stall.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low the PC is forced at once to `RESET_VEC` (default 0x00400000). After `rst_n` rises the PC keeps that value through the first two rising edges and can first change on the third.
- R2: Opcode 0 (bits 31:26) with any funct (bits 5:0) other than 8, and every opcode other than 0, 2, 3, 4 and 5, selects PC+4 and leaves `link_we` low.
- R3: Opcode 4 is branch-if-equal. When `rs_val` equals `rt_val` the next address is the branch target; otherwise it is PC+4.
- R4: Opcode 5 is branch-if-not-equal. When `rs_val` differs from `rt_val` the next address is the branch target; otherwise it is PC+4.
- R5: The branch target is PC+4 plus the 16-bit field in bits 15:0, shifted left by two and sign-extended to 32 bits. From 0x00400020 an offset of 2 reaches 0x0040002C, and an offset of -1 reaches 0x00400020 itself.
- R6: Opcode 2 is a jump. Its target is bits 31:28 of PC+4 (not of PC), then instruction bits 25:0, then two zero bits.
- R7: Opcode 3 is jump-and-link. It jumps like opcode 2, and in the same cycle it drives `link_we`=1, `link_addr`=31 and `link_data`=PC+4. In every other cycle `link_we`, `link_addr` and `link_data` are all zero.
- R8: Opcode 0 with funct 8 is a register jump. The next address is the full 32-bit `rs_val`, with no alignment applied.
- R9: While `en` is low the PC keeps its value and `link_we` stays low.
- R10: `next_pc` shows the selected address combinationally, and an enabled rising edge loads `pc` with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Advance enable; low freezes the PC |
| instr | input | 32 | Instruction word fetched from `pc` |
| rs_val | input | 32 | Register value read at field 25:21 |
| rt_val | input | 32 | Register value read at field 20:16 |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded at the next enabled edge |
| link_we | output | 1 | Link register write request |
| link_addr | output | 5 | Link register index (31 when writing) |
| link_data | output | 32 | Return address to write (PC+4) |

## Verification
The assertions take for granted that `instr`, `rs_val` and `rt_val` stay settled through the whole cycle, and that `en` is driven to a known level from the first edge after reset. They compare `next_pc` against `pc`, `rs_val` and `rt_val` sampled at that same edge. The bench changes inputs only on falling edges and keeps `en` defined at all times. It places the PC at each chosen address through a register jump, so every branch and jump scenario starts from a known, sampled PC.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OP_W-1:0] OPC_JMP  = 6'd2;
  localparam logic [OP_W-1:0] OPC_CALL = 6'd3;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'd4;
  localparam logic [OP_W-1:0] OPC_BNE  = 6'd5;
  localparam logic [FN_W-1:0] FN_RJMP  = 6'd8;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_ABS = 2'd2,
    SEL_REG = 2'd3
  } nsel_t;

  typedef struct packed {
    logic br_eq;
    logic br_ne;
    logic jmp;
    logic call;
    logic rjmp;
  } flow_t;

endpackage

// File: rtl/pcseq_rst_sync.sv
module pcseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output flow_t           flow
);

  always_comb begin
    flow = '0;
    unique case (opcode)
      OPC_BEQ:  flow.br_eq = 1'b1;
      OPC_BNE:  flow.br_ne = 1'b1;
      OPC_JMP:  flow.jmp   = 1'b1;
      OPC_CALL: flow.call  = 1'b1;
      OPC_REG:  flow.rjmp  = (funct == FN_RJMP);
      default:  flow = '0;
    endcase
  end

endmodule

// File: rtl/pcseq_targets.sv
module pcseq_targets #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int JFLD_W  = 26
) (
  input  logic [ADDR_W-1:0] pc_inc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JFLD_W-1:0] jfield,
  output logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] abs_target
);

  localparam int SHIFT    = 2;
  localparam int EXT_W    = ADDR_W - IMM_W - SHIFT;
  localparam int REGION_W = ADDR_W - JFLD_W - SHIFT;

  logic [ADDR_W-1:0] br_disp;

  always_comb begin
    br_disp    = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
    br_target  = pc_inc + br_disp;
    abs_target = {pc_inc[ADDR_W-1 -: REGION_W], jfield, {SHIFT{1'b0}}};
  end

endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
  import pcseq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGIDX_W = 5,
  parameter int LINK_REG = 31
) (
  input  logic                en,
  input  flow_t               flow,
  input  logic [ADDR_W-1:0]   rs_val,
  input  logic [ADDR_W-1:0]   rt_val,
  input  logic [ADDR_W-1:0]   pc_inc,
  input  logic [ADDR_W-1:0]   br_target,
  input  logic [ADDR_W-1:0]   abs_target,
  output nsel_t               sel,
  output logic [ADDR_W-1:0]   next_addr,
  output logic                link_we,
  output logic [REGIDX_W-1:0] link_addr,
  output logic [ADDR_W-1:0]   link_data
);

  logic same;
  logic taken;

  always_comb begin
    same  = (rs_val == rt_val);
    taken = (flow.br_eq && same) || (flow.br_ne && !same);
    if (flow.rjmp)                 sel = SEL_REG;
    else if (flow.jmp || flow.call) sel = SEL_ABS;
    else if (taken)                sel = SEL_BR;
    else                           sel = SEL_SEQ;
  end

  always_comb begin
    unique case (sel)
      SEL_BR:  next_addr = br_target;
      SEL_ABS: next_addr = abs_target;
      SEL_REG: next_addr = rs_val;
      default: next_addr = pc_inc;
    endcase
  end

  always_comb begin
    link_we   = flow.call && en;
    link_addr = link_we ? REGIDX_W'(LINK_REG) : '0;
    link_data = link_we ? pc_inc : '0;
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          REGIDX_W  = 5,
  parameter int          LINK_REG  = 31,
  parameter int          SYNC_STG  = 2,
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [31:0]         instr,
  input  logic [ADDR_W-1:0]   rs_val,
  input  logic [ADDR_W-1:0]   rt_val,
  output logic [ADDR_W-1:0]   pc,
  output logic [ADDR_W-1:0]   next_pc,
  output logic                link_we,
  output logic [REGIDX_W-1:0] link_addr,
  output logic [ADDR_W-1:0]   link_data
);

  localparam int IMM_W  = 16;
  localparam int JFLD_W = 26;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic              rst_int_n;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] br_target;
  logic [ADDR_W-1:0] abs_target;
  flow_t             flow;
  nsel_t             sel;

  pcseq_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pcseq_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .flow   (flow)
  );

  always_comb pc_inc = pc_q + STEP;

  pcseq_targets #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .JFLD_W (JFLD_W)
  ) u_tgt (
    .pc_inc     (pc_inc),
    .imm        (instr[IMM_W-1:0]),
    .jfield     (instr[JFLD_W-1:0]),
    .br_target  (br_target),
    .abs_target (abs_target)
  );

  pcseq_select #(
    .ADDR_W   (ADDR_W),
    .REGIDX_W (REGIDX_W),
    .LINK_REG (LINK_REG)
  ) u_sel (
    .en         (en),
    .flow       (flow),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .pc_inc     (pc_inc),
    .br_target  (br_target),
    .abs_target (abs_target),
    .sel        (sel),
    .next_addr  (pc_d),
    .link_we    (link_we),
    .link_addr  (link_addr),
    .link_data  (link_data)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  pc_q <= ADDR_W'(RESET_VEC);
    else if (en)     pc_q <= pc_d;
  end

  assign pc      = pc_q;
  assign next_pc = pc_d;

  // R10
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && rst_int_n) |=> (pc == $past(next_pc)));

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en) |=> $stable(pc));

  // R9
  no_link_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en) |-> !link_we);

  // R7
  link_data_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    link_we |-> (link_addr == REGIDX_W'(LINK_REG) && link_data == pc + STEP));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel == SEL_SEQ) |-> (next_pc == pc + STEP));

  // R8
  reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel == SEL_REG) |-> (next_pc == rs_val));

  // R5
  br_align_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel == SEL_BR) |-> (next_pc[1:0] == pc[1:0]));

  // R3
  beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flow.br_eq && rs_val == rt_val) |-> (sel == SEL_BR));

  // R4
  bne_taken_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flow.br_ne && rs_val != rt_val) |-> (sel == SEL_BR));

  // R6
  abs_region_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel == SEL_ABS) |-> (next_pc[31:28] == pc_inc[31:28] && next_pc[1:0] == 2'b00));

endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] pc;
  logic [31:0] next_pc;
  logic        link_we;
  logic [4:0]  link_addr;
  logic [31:0] link_data;

  int checks;
  int fails;
  bit done;

  pc_sequencer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .instr     (instr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .pc        (pc),
    .next_pc   (next_pc),
    .link_we   (link_we),
    .link_addr (link_addr),
    .link_data (link_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd16, 5'd17, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] a);
    return {op, a};
  endfunction

  function automatic logic [31:0] enc_r(input logic [5:0] fn);
    return {6'd0, 5'd9, 5'd0, 5'd0, 5'd0, fn};
  endfunction

  task automatic ck(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic place_pc(input logic [31:0] a);
    en = 1'b1; instr = enc_r(6'd8); rs_val = a; rt_val = '0;
    step();
    instr = 32'h0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; instr = 32'h0; rs_val = '0; rt_val = '0;
    step(); step();
    ck(pc == 32'h0040_0000, "R1 reset value", pc, 32'h0040_0000);
    ck(link_we == 1'b0, "R1 no link in reset", {31'd0, link_we}, 32'd0);
    rst_n = 1'b1; en = 1'b1;
    step();
    ck(pc == 32'h0040_0000, "R1 first edge after release", pc, 32'h0040_0000);
    step();
    ck(pc == 32'h0040_0000, "R1 second edge after release", pc, 32'h0040_0000);
    step();
    ck(pc == 32'h0040_0004, "R1 third edge advances", pc, 32'h0040_0004);
  endtask

  task automatic t_seq();
    place_pc(32'h0000_1000);
    instr = 32'h0234_4020; // R-type funct 0x20
    #1 ck(next_pc == 32'h0000_1004, "R2 other funct", next_pc, 32'h0000_1004);
    ck(!link_we, "R2 no link", {31'd0, link_we}, 32'd0);
    step();
    ck(pc == 32'h0000_1004, "R2 pc after R-type", pc, 32'h0000_1004);
    instr = enc_i(6'd35, 16'hFFFF);
    #1 ck(next_pc == 32'h0000_1008, "R2 other opcode", next_pc, 32'h0000_1008);
    instr = enc_r(6'd9);
    #1 ck(next_pc == 32'h0000_1008, "R2 funct 9 not a jump", next_pc, 32'h0000_1008);
    step();
    ck(pc == 32'h0000_1008, "R2 pc sequential", pc, 32'h0000_1008);
  endtask

  task automatic t_beq();
    place_pc(32'h0040_0020);
    instr = enc_i(6'd4, 16'd2); rs_val = 32'd7; rt_val = 32'd7;
    #1 ck(next_pc == 32'h0040_002C, "R3 beq taken next_pc", next_pc, 32'h0040_002C);
    step();
    ck(pc == 32'h0040_002C, "R5 beq offset 2", pc, 32'h0040_002C);
    place_pc(32'h0040_0020);
    instr = enc_i(6'd4, 16'hFFFF); rs_val = 32'd5; rt_val = 32'd5;
    step();
    ck(pc == 32'h0040_0020, "R5 beq offset -1 to itself", pc, 32'h0040_0020);
    instr = enc_i(6'd4, 16'd2); rs_val = 32'd5; rt_val = 32'd6;
    step();
    ck(pc == 32'h0040_0024, "R3 beq not taken", pc, 32'h0040_0024);
    place_pc(32'h0004_0000);
    instr = enc_i(6'd4, 16'h8000); rs_val = '0; rt_val = '0;
    step();
    ck(pc == 32'h0002_0004, "R5 most negative offset", pc, 32'h0002_0004);
  endtask

  task automatic t_bne();
    place_pc(32'h0040_0100);
    instr = enc_i(6'd5, 16'h0010); rs_val = 32'h8000_0000; rt_val = 32'h0;
    step();
    ck(pc == 32'h0040_0144, "R4 bne taken", pc, 32'h0040_0144);
    instr = enc_i(6'd5, 16'h0010); rs_val = 32'hDEAD_BEEF; rt_val = 32'hDEAD_BEEF;
    step();
    ck(pc == 32'h0040_0148, "R4 bne not taken", pc, 32'h0040_0148);
  endtask

  task automatic t_jump();
    place_pc(32'hA000_0010);
    instr = enc_j(6'd2, 26'h3FF_FFFF);
    step();
    ck(pc == 32'hAFFF_FFFC, "R6 jump in region", pc, 32'hAFFF_FFFC);
    ck(!link_we, "R6 jump no link", {31'd0, link_we}, 32'd0);
    place_pc(32'hEFFF_FFFC);
    instr = enc_j(6'd2, 26'h0);
    step();
    ck(pc == 32'hF000_0000, "R6 region from pc+4", pc, 32'hF000_0000);
  endtask

  task automatic t_call();
    place_pc(32'h0040_0200);
    instr = enc_j(6'd3, 26'h010_0400);
    #1 ck(link_we == 1'b1, "R7 link_we", {31'd0, link_we}, 32'd1);
    ck(link_addr == 5'd31, "R7 link_addr", {27'd0, link_addr}, 32'd31);
    ck(link_data == 32'h0040_0204, "R7 link_data", link_data, 32'h0040_0204);
    step();
    ck(pc == 32'h0040_1000, "R7 call target", pc, 32'h0040_1000);
    instr = 32'h0;
    #1 ck(link_we == 1'b0 && link_data == '0, "R7 link one cycle", link_data, 32'd0);
    instr = enc_r(6'd8); rs_val = 32'h0040_0204;
    step();
    ck(pc == 32'h0040_0204, "R8 return via register", pc, 32'h0040_0204);
  endtask

  task automatic t_regjump();
    place_pc(32'h1234_5677);
    ck(pc == 32'h1234_5677, "R8 unaligned kept", pc, 32'h1234_5677);
    instr = enc_r(6'd8); rs_val = 32'hFFFF_FFFC;
    #1 ck(next_pc == 32'hFFFF_FFFC, "R10 next_pc shown", next_pc, 32'hFFFF_FFFC);
    step();
    ck(pc == 32'hFFFF_FFFC, "R10 loaded", pc, 32'hFFFF_FFFC);
  endtask

  task automatic t_hold();
    place_pc(32'h0000_0800);
    en = 1'b0;
    instr = enc_j(6'd3, 26'h0);
    #1 ck(!link_we, "R9 no link while held", {31'd0, link_we}, 32'd0);
    step(); step();
    ck(pc == 32'h0000_0800, "R9 pc held", pc, 32'h0000_0800);
    en = 1'b1; instr = 32'h0;
    step();
    ck(pc == 32'h0000_0804, "R9 resumes", pc, 32'h0000_0804);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; en = 1'b0; instr = '0; rs_val = '0; rt_val = '0;
    @(negedge clk);
    t_reset();
    t_seq();
    t_beq();
    t_bne();
    t_jump();
    t_call();
    t_regjump();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule